// File: doc/BRIEF.md
# Parallel Double-Buffered Quad DAC Loader

This block is the digital front end of a four-channel, 8-bit voltage DAC fed from a byte-wide parallel bus. A two-bit address picks one of four input registers, and an active-low write strobe lets the picked register follow the bus. A second active-low strobe, the load control, lets all four DAC registers follow their input registers at once. Host software can therefore preload every channel and then move all outputs in the same cycle. Holding the load control low turns the part into a single-buffered loader, where a write reaches its output straight away.

Both register stages behave as level-sensitive latches, modelled on the system clock. Each cycle in which the write level is active, the addressed input register takes the bus. Each cycle in which the load level is active, every DAC register takes the value that its input register holds after this cycle's write. Every pin passes through a two-flop synchroniser as one aligned word. A shutdown input stands for a floating address pin and turns off the global output enable. It leaves every register untouched. An active-low reset stands in for power-on reset.

Top module: `qdac_par_ctrl`

## Requirements
- R1: After reset, all four DAC codes read 0x00 and the output enable reads 1. Every input register also holds 0x00, and a load with no prior write shows this.
- R2: The address selects the input register: 0 is channel A, 1 is B, 2 is C and 3 is D. Channel n drives `dac_codes_o[8n+7:8n]`, and data bit 7 is the MSB.
- R3: While the write strobe is low, the addressed input register takes the bus value and the other three keep their contents. While it is high, no input register changes.
- R4: While the load strobe is low, all four DAC registers take their input registers' values.
- R5: While the load strobe is high, no DAC code changes, whatever the write strobe and bus do.
- R6: With write and load both low, the addressed channel's DAC code follows the bus through both stages in a single step.
- R7: While shutdown is high, the output enable is 0. Register contents are kept, and both stages keep working. When shutdown is released, the enable returns to 1.
- R8: A change on any input is visible at the outputs after exactly three rising clock edges: two synchroniser stages, then one register update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, stands for power-on reset |
| data_i | input | 8 | Parallel data bus, bit 7 MSB |
| addr_i | input | 2 | Input register select |
| wr_n_i | input | 1 | Active-low write level |
| ldac_n_i | input | 1 | Active-low load level for all DAC registers |
| shdn_i | input | 1 | Shutdown request (floating address pin, detected outside) |
| dac_codes_o | output | 32 | Four DAC codes, channel n at bits 8n+7:8n |
| out_en_o | output | 1 | Global output enable, 0 in shutdown |

## Verification
The hardest case to reach is write and load both active in the same synchronised cycle. In that case the addressed DAC register must take the new bus value and not the input register's previous contents. The other three channels must still copy their own input registers. Random transactions pull the load strobe low about a third of the time and the write strobe half the time, so this overlap comes up again and again across all addresses. A directed step also counts edges to confirm that it shows up on the third edge and not before.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  localparam int unsigned QDAC_SYNC_STAGES = 2;

  // low bit index of one channel lane in a flat code vector
  function automatic int unsigned lane_lo(input int unsigned ch, input int unsigned w);
    return ch * w;
  endfunction

  // one-hot write enable for a channel address, all zero when idle
  function automatic logic [15:0] sel_onehot(input logic active, input logic [3:0] addr);
    logic [15:0] v;
    v = '0;
    if (active) v[addr] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/qdac_in_bank.sv
module qdac_in_bank
  import qdac_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned NCH   = 1 << ADDR_W,
  localparam int unsigned VEC_W = NCH * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_act,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] data,
  output logic [VEC_W-1:0]  in_q_o,
  output logic [VEC_W-1:0]  in_next_o
);
  logic [15:0]    sel_full;
  logic [NCH-1:0] wen;

  assign sel_full = sel_onehot(wr_act, 4'(addr));
  assign wen      = sel_full[NCH-1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    localparam int unsigned LO = i * CODE_W;
    assign in_next_o[LO +: CODE_W] = wen[i] ? data : in_q_o[LO +: CODE_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_q_o[LO +: CODE_W] <= '0;
      else        in_q_o[LO +: CODE_W] <= in_next_o[LO +: CODE_W];
    end
  end

  // R2: at most one channel is written per cycle
  p_one_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wen));

  // R3: no input register moves while the write level is inactive
  p_in_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_act |=> $stable(in_q_o));
endmodule

// File: rtl/qdac_out_bank.sv
module qdac_out_bank #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned NCH    = 4,
  localparam int unsigned VEC_W = NCH * CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_act,
  input  logic             shdn_act,
  input  logic [VEC_W-1:0] in_next,
  output logic [VEC_W-1:0] dac_q_o,
  output logic             oe_q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q_o <= '0;
      oe_q_o  <= 1'b1;
    end else begin
      if (ld_act) dac_q_o <= in_next;
      oe_q_o <= !shdn_act;
    end
  end

  // R5: DAC codes hold while the load level is inactive
  p_dac_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_act |=> $stable(dac_q_o));

  // R7: shutdown drops the enable on the next edge
  p_oe_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_act |=> !oe_q_o);
endmodule

// File: rtl/qdac_par_ctrl.sv
module qdac_par_ctrl
  import qdac_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned NCH   = 1 << ADDR_W,
  localparam int unsigned VEC_W = NCH * CODE_W,
  localparam int unsigned SW    = CODE_W + ADDR_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_n_i,
  input  logic              ldac_n_i,
  input  logic              shdn_i,
  output logic [VEC_W-1:0]  dac_codes_o,
  output logic              out_en_o
);
  localparam logic [SW-1:0] IDLE_WORD = {1'b0, 1'b1, 1'b1, {ADDR_W{1'b0}}, {CODE_W{1'b0}}};

  logic [SW-1:0]     raw_w, syn_w;
  logic [CODE_W-1:0] data_s;
  logic [ADDR_W-1:0] addr_s;
  logic              wr_n_s, ldac_n_s, shdn_s;
  logic              wr_act, ld_act;
  logic [VEC_W-1:0]  in_q, in_next;

  assign raw_w = {shdn_i, ldac_n_i, wr_n_i, addr_i, data_i};

  qdac_sync #(.WIDTH(SW), .STAGES(QDAC_SYNC_STAGES), .RST_VAL(IDLE_WORD)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_w), .q_o(syn_w)
  );

  assign {shdn_s, ldac_n_s, wr_n_s, addr_s, data_s} = syn_w;
  assign wr_act = !wr_n_s;
  assign ld_act = !ldac_n_s;

  qdac_in_bank #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_in (
    .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .addr(addr_s), .data(data_s),
    .in_q_o(in_q), .in_next_o(in_next)
  );

  qdac_out_bank #(.CODE_W(CODE_W), .NCH(NCH)) u_out (
    .clk(clk), .rst_n(rst_n), .ld_act(ld_act), .shdn_act(shdn_s),
    .in_next(in_next), .dac_q_o(dac_codes_o), .oe_q_o(out_en_o)
  );

  // R4: after a load cycle every DAC register equals its input register
  p_dac_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_act |=> dac_codes_o == in_q);

  // R7: releasing shutdown restores the enable
  p_oe_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_s |=> out_en_o);

  // R6: write and load together put the bus on the addressed lane
  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act && ld_act) |=> dac_codes_o[lane_lo(32'($past(addr_s)), CODE_W) +: CODE_W] == $past(data_s));
endmodule

// File: tb/qdac_par_ctrl_tb.sv
module qdac_par_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  data_i = '0;
  logic [1:0]  addr_i = '0;
  logic        wr_n_i = 1'b1;
  logic        ldac_n_i = 1'b1;
  logic        shdn_i = 1'b0;
  logic [31:0] dac_codes_o;
  logic        out_en_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] m_in [4];
  logic [7:0] m_dac [4];

  always #2.5 clk = ~clk;

  qdac_par_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .data_i(data_i), .addr_i(addr_i), .wr_n_i(wr_n_i),
    .ldac_n_i(ldac_n_i), .shdn_i(shdn_i), .dac_codes_o(dac_codes_o), .out_en_o(out_en_o)
  );

  function automatic logic [7:0] lane(input logic [31:0] v, input int ch);
    return v[ch*8 +: 8];
  endfunction

  // reference model: write first, then load copies the updated input registers
  task automatic model_step(input logic [7:0] d, input logic [1:0] a, input logic w_n,
                            input logic l_n);
    if (!w_n) m_in[a] = d;
    if (!l_n) for (int c = 0; c < 4; c++) m_dac[c] = m_in[c];
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int c = 0; c < 4; c++) chk(req, 32'(lane(dac_codes_o, c)), 32'(m_dac[c]));
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [7:0] d, input logic [1:0] a, input logic w_n,
                       input logic l_n, input logic s);
    data_i = d; addr_i = a; wr_n_i = w_n; ldac_n_i = l_n; shdn_i = s;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int c = 0; c < 4; c++) begin m_in[c] = '0; m_dac[c] = '0; end

    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1: reset state
    chk("R1 codes", dac_codes_o, 32'h0);
    chk("R1 oe", 32'(out_en_o), 32'd1);

    // R1: load without write exposes zeroed input registers
    drive(8'hEE, 2'd0, 1'b1, 1'b0, 1'b0); cyc(4);
    chk("R1 input regs", dac_codes_o, 32'h0);
    drive(8'h00, 2'd0, 1'b1, 1'b1, 1'b0); cyc(4);

    // R3/R5: preload all channels with load high, outputs must not move
    for (int c = 0; c < 4; c++) begin
      drive(8'(8'h11 * (c + 1)), 2'(c), 1'b0, 1'b1, 1'b0); cyc(4);
      model_step(8'(8'h11 * (c + 1)), 2'(c), 1'b0, 1'b1);
      chk("R5 hold during write", dac_codes_o, 32'h0);
    end
    drive(8'h99, 2'd1, 1'b1, 1'b1, 1'b0); cyc(4);
    chk("R5 idle", dac_codes_o, 32'h0);

    // R4/R2: simultaneous update, lane order A..D
    drive(8'h99, 2'd1, 1'b1, 1'b0, 1'b0); cyc(4);
    model_step(8'h99, 2'd1, 1'b1, 1'b0);
    chk("R2 R4 lane map", dac_codes_o, 32'h44332211);
    drive(8'h99, 2'd1, 1'b1, 1'b1, 1'b0); cyc(4);

    // R6/R8: both strobes low on channel C, count edges
    drive(8'hA5, 2'd2, 1'b0, 1'b0, 1'b0);
    cyc(2);
    chk("R8 before third edge", 32'(lane(dac_codes_o, 2)), 32'h33);
    cyc(1);
    chk("R6 R8 pass-through", 32'(lane(dac_codes_o, 2)), 32'hA5);
    model_step(8'hA5, 2'd2, 1'b0, 1'b0);
    chk_all("R6 other lanes");
    drive(8'hA5, 2'd2, 1'b1, 1'b1, 1'b0); cyc(4);

    // R3: write to D with load high, then load shows only D changed
    drive(8'h5A, 2'd3, 1'b0, 1'b1, 1'b0); cyc(4);
    model_step(8'h5A, 2'd3, 1'b0, 1'b1);
    drive(8'h5A, 2'd3, 1'b1, 1'b0, 1'b0); cyc(4);
    model_step(8'h5A, 2'd3, 1'b1, 1'b0);
    chk("R3 single lane write", dac_codes_o, 32'h5AA52211);
    drive(8'h00, 2'd0, 1'b1, 1'b1, 1'b0); cyc(4);

    // R7/R8: shutdown timing and retention
    drive(8'h00, 2'd0, 1'b1, 1'b1, 1'b1);
    cyc(2);
    chk("R8 oe before third edge", 32'(out_en_o), 32'd1);
    cyc(1);
    chk("R7 oe off", 32'(out_en_o), 32'd0);
    chk_all("R7 codes kept");
    drive(8'h3C, 2'd0, 1'b0, 1'b0, 1'b1); cyc(4);
    model_step(8'h3C, 2'd0, 1'b0, 1'b0);
    chk_all("R7 regs still work in shutdown");
    drive(8'h3C, 2'd0, 1'b1, 1'b1, 1'b0); cyc(4);
    chk("R7 oe back on", 32'(out_en_o), 32'd1);

    // random transactions
    for (int t = 0; t < 400; t++) begin
      logic [7:0] d;
      logic [1:0] a;
      logic w_n, l_n, s;
      d = 8'($urandom);
      a = 2'($urandom);
      w_n = ($urandom % 2) != 0;
      l_n = ($urandom % 3) != 0;
      s = ($urandom % 8) == 0;
      drive(d, a, w_n, l_n, s); cyc(4);
      model_step(d, a, w_n, l_n);
      chk_all("R3 R4 R5 R6 random");
      chk("R7 random oe", 32'(out_en_o), 32'(!s));
    end

    finish_run();
  end
endmodule